// File: doc/BRIEF.md
# Word-Load Mailbox with Running CRC-16

This block sits behind a 16-bit register port and lets a host fill an internal memory one 32-bit word at a time. The host sets a word address through two 16-bit registers, optionally zeroes the running checksum, then for every word writes its upper and lower halves into two data registers and issues a commit command through the control register. On commit the block drives one memory write, steps the address, and folds the word into a CRC-16 over four cycles, one byte per cycle, most-significant byte first.

When the load is done the host reads the checksum register and compares it with its own computation over the same bytes in the same order. Register bits travel straight through: bit n of any register is bit n of the bus value, so no byte swapping exists anywhere on the register path.

Top module: `mbox_crc_loader`

## Requirements
- R1: After a synchronous active-high reset every readable register reads 0, `busy` is 0 and `mem_we` is 0.
- R2: Register index map on `reg_addr`: 0 control, 1 address upper half, 2 address lower half, 3 data upper half (word bits 31:16), 4 data lower half (word bits 15:0), 5 CRC; indices 6 and 7 read 0. Reading control returns `busy` in bit 0. `reg_rdata` shows the register selected by `reg_addr` one clock after it is presented, with bit n of the register on bit n of the bus.
- R3: Writes to the address and data registers alone never pulse `mem_we` and never change the CRC.
- R4: A write to control with bit 0 set (commit), accepted while not busy, pulses `mem_we` for exactly one cycle on the next clock with `mem_wdata` = {data upper, data lower} and `mem_addr` = the low `MEM_AW` bits of the word address held before the commit.
- R5: Each accepted commit increments the 32-bit word address by one, carrying from the lower into the upper register half.
- R6: The CRC uses polynomial 0x1021, no bit reflection, no final XOR, and absorbs each committed word as bytes 31:24, 23:16, 15:8, 7:0 in that order, one byte per clock on the four clocks after the commit.
- R7: `busy` is high for exactly four cycles after an accepted commit; any control write arriving while busy (commit and clear alike) is ignored.
- R8: Control bit 1 (clear) zeroes the CRC; when clear and commit are set in the same write, the clear takes effect first so the new word starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Registered read value of the indexed register |
| busy | output | 1 | CRC fold in progress |
| mem_we | output | 1 | Memory write strobe, one cycle per word |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write word |

## Verification
Two things can land in one cycle: a clear and a commit packed into a single control write, and a new control write arriving on a cycle when the CRC fold is still running. The bench provokes the first by writing both bits at once after a non-zero CRC has built up, and the second by issuing commits and clears on the first and on the last busy cycle and then on the first free one. A behavioural model holding the pending bytes in a queue decides on every clock which writes take effect, and the memory strobe, address, data, `busy` and read value are compared against it each cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int REG_W  = 16;
  localparam int WORD_W = 2 * REG_W;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] RIDX_CTRL    = 3'd0;
  localparam logic [IDX_W-1:0] RIDX_ADDR_HI = 3'd1;
  localparam logic [IDX_W-1:0] RIDX_ADDR_LO = 3'd2;
  localparam logic [IDX_W-1:0] RIDX_DATA_HI = 3'd3;
  localparam logic [IDX_W-1:0] RIDX_DATA_LO = 3'd4;
  localparam logic [IDX_W-1:0] RIDX_CRC     = 3'd5;

  localparam int CTL_COMMIT = 0;
  localparam int CTL_CLEAR  = 1;
  localparam int STS_BUSY   = 0;

  localparam logic [15:0] CRC_POLY = 16'h1021;

  // One byte through a non-reflected CRC-16, MSB of the byte first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] cur, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction

endpackage

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_val,
  input  logic              commit,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);

  localparam int NHALF = WORD_W / REG_W;

  // Halves are written by index; half 0 is the upper half.
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam int LSB = (NHALF - 1 - h) * REG_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[LSB +: REG_W] <= '0;
      end else if (wr_en && wr_idx == RIDX_DATA_HI + IDX_W'(h)) begin
        data_q[LSB +: REG_W] <= wr_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (commit) begin
      addr_q <= addr_q + 1'b1;
    end else if (wr_en && wr_idx == RIDX_ADDR_HI) begin
      addr_q[WORD_W-1:REG_W] <= wr_val;
    end else if (wr_en && wr_idx == RIDX_ADDR_LO) begin
      addr_q[REG_W-1:0] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= commit;
      if (commit) begin
        mem_addr  <= addr_q[MEM_AW-1:0];
        mem_wdata <= data_q;
      end
    end
  end

  AST_MEM_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (addr_q == $past(addr_q) + 1'b1)); // R5
  AST_WE_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == $past(addr_q[MEM_AW-1:0]))); // R4

endmodule

// File: rtl/mbox_crc_unit.sv
module mbox_crc_unit
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              clr,
  input  logic [DATA_W-1:0] word,
  output logic              busy_q,
  output logic [15:0]       crc_q
);

  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q   <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      if (clr) crc_q <= '0;
      if (start) begin
        shreg_q <= word;
        busy_q  <= 1'b1;
        cnt_q   <= '0;
      end else if (busy_q) begin
        crc_q   <= crc16_byte(crc_q, shreg_q[DATA_W-1 -: 8]);
        shreg_q <= shreg_q << 8;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == LAST) |=> !busy_q); // R7
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    (start || clr) |-> !busy_q); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_q == 16'h0000)); // R8
  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !clr) |=> $stable(crc_q)); // R3

endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] addr_q,
  input  logic [WORD_W-1:0] data_q,
  input  logic              busy,
  input  logic [15:0]       crc,
  output logic [REG_W-1:0]  rdata_q
);

  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (rd_idx)
      RIDX_CTRL:    sel[STS_BUSY] = busy;
      RIDX_ADDR_HI: sel = addr_q[WORD_W-1:REG_W];
      RIDX_ADDR_LO: sel = addr_q[REG_W-1:0];
      RIDX_DATA_HI: sel = data_q[WORD_W-1:REG_W];
      RIDX_DATA_LO: sel = data_q[REG_W-1:0];
      RIDX_CRC:     sel = crc;
      default:      sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= sel;
  end

endmodule

// File: rtl/mbox_crc_loader.sv
module mbox_crc_loader
  import mbox_pkg::*;
#(
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              busy,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata
);

  logic              ctrl_ok;
  logic              commit;
  logic              clr;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [15:0]       crc;

  // Control writes only count while the fold engine is idle.
  assign ctrl_ok = reg_we && (reg_addr == RIDX_CTRL) && !busy;
  assign commit  = ctrl_ok && reg_wdata[CTL_COMMIT];
  assign clr     = ctrl_ok && reg_wdata[CTL_CLEAR];

  mbox_regfile #(.MEM_AW(MEM_AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_we),
    .wr_idx    (reg_addr),
    .wr_val    (reg_wdata),
    .commit    (commit),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  mbox_crc_unit #(.DATA_W(WORD_W)) u_crc (
    .clk    (clk),
    .rst    (rst),
    .start  (commit),
    .clr    (clr),
    .word   (data_q),
    .busy_q (busy),
    .crc_q  (crc)
  );

  mbox_rdmux u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (reg_addr),
    .addr_q  (addr_q),
    .data_q  (data_q),
    .busy    (busy),
    .crc     (crc),
    .rdata_q (reg_rdata)
  );

  AST_DATA_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr != RIDX_CTRL) |=> !mem_we); // R3
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we && reg_addr == RIDX_CTRL) |=> !mem_we); // R7

endmodule

// File: tb/tb_mbox_crc_loader.sv
module tb_mbox_crc_loader;

  localparam int MEM_AW = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_addr = 3'd5;
  logic [15:0]       reg_wdata = '0;
  logic [15:0]       reg_rdata;
  logic              busy;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0]       mem_wdata;

  always #4 clk = ~clk; // 125 MHz

  mbox_crc_loader #(.MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit started = 0;

  // Behavioural reference state.
  logic [31:0] m_addr, m_word;
  logic [15:0] m_crc, e_rdata;
  logic [7:0]  pend[$];
  logic        e_we;
  logic [MEM_AW-1:0] e_addr;
  logic [31:0] e_wdata;
  logic [2:0]  e_ridx;

  function automatic logic [15:0] ref_step(logic [15:0] c, logic [7:0] b);
    logic [15:0] x;
    x = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  always @(posedge clk) begin
    bit was_busy;
    started <= 1;
    if (rst) begin
      m_addr = 0; m_word = 0; m_crc = 0; pend.delete();
      e_we = 0; e_addr = 0; e_wdata = 0; e_rdata = 0; e_ridx = 0;
    end else begin
      was_busy = (pend.size() != 0);
      e_ridx = reg_addr;
      case (reg_addr)
        3'd0: e_rdata = {15'd0, was_busy};
        3'd1: e_rdata = m_addr[31:16];
        3'd2: e_rdata = m_addr[15:0];
        3'd3: e_rdata = m_word[31:16];
        3'd4: e_rdata = m_word[15:0];
        3'd5: e_rdata = m_crc;
        default: e_rdata = 0;
      endcase
      e_we = 0;
      if (was_busy) m_crc = ref_step(m_crc, pend.pop_front());
      if (reg_we) begin
        case (reg_addr)
          3'd1: m_addr[31:16] = reg_wdata;
          3'd2: m_addr[15:0]  = reg_wdata;
          3'd3: m_word[31:16] = reg_wdata;
          3'd4: m_word[15:0]  = reg_wdata;
          3'd0: if (!was_busy) begin
            if (reg_wdata[1]) m_crc = 0;
            if (reg_wdata[0]) begin
              e_we = 1; e_addr = m_addr[MEM_AW-1:0]; e_wdata = m_word;
              m_addr = m_addr + 1;
              pend.push_back(m_word[31:24]); pend.push_back(m_word[23:16]);
              pend.push_back(m_word[15:8]);  pend.push_back(m_word[7:0]);
            end
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s @%0t got=%h exp=%h", tag, $time, got, exp);
    end
  endtask

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R4 mem_we", {31'd0, mem_we}, {31'd0, e_we});
      if (e_we) begin
        chk("R4 mem_wdata", mem_wdata, e_wdata);
        chk("R5 mem_addr", {20'd0, mem_addr}, {20'd0, e_addr});
      end
      chk("R7 busy", {31'd0, busy}, {31'd0, pend.size() != 0});
      if (e_ridx == 3'd5) chk("R6 crc readback", {16'd0, reg_rdata}, {16'd0, e_rdata});
      else                chk("R2 readback", {16'd0, reg_rdata}, {16'd0, e_rdata});
    end
  end

  task automatic wr(logic [2:0] idx, logic [15:0] v);
    reg_we = 1; reg_addr = idx; reg_wdata = v;
    @(negedge clk);
    reg_we = 0; reg_addr = 3'd5;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [31:0] w);
    wr(3'd3, w[31:16]);
    wr(3'd4, w[15:0]);
    wr(3'd0, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state through ports
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 mem_we", {31'd0, mem_we}, 0);
    chk("R1 crc", {16'd0, reg_rdata}, 0);
    for (int i = 0; i < 8; i++) begin reg_addr = 3'(i); @(negedge clk); end
    reg_addr = 3'd5;

    // R5: carry from lower into upper address half
    wr(3'd1, 16'h0000); wr(3'd2, 16'hFFFE);
    wr(3'd0, 16'h0002);
    load(32'h31323334); idle(5);
    load(32'h35363738); idle(5);
    load(32'hA5A5_0F0F); idle(5);
    // R3: data writes without commit
    wr(3'd3, 16'hDEAD); wr(3'd4, 16'hBEEF); idle(6);
    // R7: commits and clear while busy are ignored
    wr(3'd0, 16'h0001);
    wr(3'd0, 16'h0003); idle(2);
    wr(3'd0, 16'h0001);            // sampled on last busy cycle
    wr(3'd0, 16'h0001); idle(5);   // accepted
    // R8: clear and commit together after a non-zero CRC
    wr(3'd3, 16'h1234); wr(3'd4, 16'h5678);
    wr(3'd0, 16'h0003); idle(6);
    // R6: varied words, zero and all-ones
    load(32'h0000_0000); idle(4);
    load(32'hFFFF_FFFF); idle(4);
    for (int i = 0; i < 24; i++) begin
      load($urandom);
      idle($urandom_range(3, 7));
      if (i % 8 == 7) wr(3'd0, 16'h0002);
    end
    // R2: read every index
    wr(3'd1, 16'hC001); wr(3'd2, 16'h0FF0);
    for (int i = 0; i < 8; i++) begin reg_addr = 3'(i); @(negedge clk); end
    reg_addr = 3'd5; idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule